// File: doc/BRIEF.md
# Shared-Memory Address Generator for a Convolution Engine

This block turns the high-level fetch and store commands of a convolution datapath into word-aligned byte addresses inside a shared DRAM window. Software places the weights at the start of the window and the activation data directly after them. It then programs a small set of registers over a plain write port: the window base, a global weight offset, a data offset, per-layer weight and input offsets, the number of words per image row, and the current output pixel offset.

The datapath issues four kinds of command:
- a weight read at any weight index,
- an input-row select, which reloads an internal pixel pointer,
- a streaming pixel read, which uses the pointer and then advances it by one word,
- an output write for a given output channel.

Each accepted memory command becomes one request on a valid/ready memory port. Only one request can be outstanding at a time. A command whose word address falls outside the window is dropped and raises a one-cycle error pulse.

Top module: `cnn_dram_addrgen`

## Requirements
- R1: After reset there is no memory request, `cmd_ready` is high and `err` is low. The base register holds 0x3800_0000 and every other register holds 0.
- R2: A weight read (`cmd_op`=0) requests byte address base + 4·(global weight offset + layer weight offset + `cmd_arg`), with `mem_write` low.
- R3: A row select (`cmd_op`=3) sets the pixel pointer to layer input offset + row words · `cmd_arg`. It makes no memory request and raises no error.
- R4: A pixel read (`cmd_op`=1) requests base + 4·(data offset + pointer). Once the request is issued, the pointer grows by one.
- R5: An output write (`cmd_op`=2) requests base + 4·(data offset + output pixel offset + `cmd_arg`), with `mem_write` high and `mem_wdata` equal to `cmd_wdata`.
- R6: A memory command whose word address is at or above region size/4 (0x0180_0000 by default) issues no request. It drives `err` high for exactly the cycle after acceptance and leaves the pixel pointer unchanged.
- R7: A request appears on the cycle after its command is accepted and stays stable until `mem_ready`. `cmd_ready` is low while a request is pending, and commands offered then are ignored.
- R8: Every requested byte address has its two low bits at zero.
- R9: The configuration write selects a register with `cfg_sel`: 0 base, 1 global weight offset, 2 data offset, 3 layer weight offset, 4 layer input offset, 5 row words, 6 output pixel offset. The new value is used from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_data | input | ADDR_W | Configuration value |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | Command kind: 0 weight, 1 pixel, 2 output, 3 row |
| cmd_arg | input | ARG_W | Weight index, output channel or row |
| cmd_wdata | input | DATA_W | Data for an output write |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| mem_valid | output | 1 | Memory request pending |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory takes the request |
| err | output | 1 | Out-of-window command dropped |

## Verification
A corrupted pixel pointer shows up on the very next pixel read as an address that is off by a fixed stride, and it keeps that offset until the next row select. A wrong offset sum or a wrong register select shows up as a bad `mem_addr` one cycle after the command. A faulty range comparison at the window edge shows up the cycle after acceptance as either a missing `err` pulse or a request that should not exist. If the pending-request state is lost, the request drops or shifts before `mem_ready`, or a command offered during a stall leaves the next streaming address one word too far along.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    OP_WGT = 2'd0,
    OP_PIX = 2'd1,
    OP_OUT = 2'd2,
    OP_ROW = 2'd3
  } dag_op_e;

  typedef enum logic [2:0] {
    CF_BASE  = 3'd0,
    CF_WOFS  = 3'd1,
    CF_DOFS  = 3'd2,
    CF_LWOFS = 3'd3,
    CF_LIN   = 3'd4,
    CF_PPR   = 3'd5,
    CF_OPIX  = 3'd6
  } dag_cfg_e;
endpackage

// File: rtl/dag_cfg_regs.sv
module dag_cfg_regs
  import dag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_BASE = 32'h3800_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] wofs_q,
  output logic [ADDR_W-1:0] dofs_q,
  output logic [ADDR_W-1:0] lwofs_q,
  output logic [ADDR_W-1:0] lin_q,
  output logic [ADDR_W-1:0] ppr_q,
  output logic [ADDR_W-1:0] opix_q
);
  localparam int NREG = 7;

  logic [NREG-1:0] hit;

  // One write strobe per register, decoded from the select code.
  generate
    for (genvar i = 0; i < NREG; i++) begin : g_dec
      assign hit[i] = cfg_we && (cfg_sel == 3'(i));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= RESET_BASE;
      wofs_q  <= '0;
      dofs_q  <= '0;
      lwofs_q <= '0;
      lin_q   <= '0;
      ppr_q   <= '0;
      opix_q  <= '0;
    end else begin
      if (hit[CF_BASE])  base_q  <= cfg_data;
      if (hit[CF_WOFS])  wofs_q  <= cfg_data;
      if (hit[CF_DOFS])  dofs_q  <= cfg_data;
      if (hit[CF_LWOFS]) lwofs_q <= cfg_data;
      if (hit[CF_LIN])   lin_q   <= cfg_data;
      if (hit[CF_PPR])   ppr_q   <= cfg_data;
      if (hit[CF_OPIX])  opix_q  <= cfg_data;
    end
  end
endmodule

// File: rtl/dag_pixel_ptr.sv
module dag_pixel_ptr #(
  parameter int ADDR_W = 32,
  parameter int ARG_W  = 16,
  parameter int PTR_W  = ADDR_W + ARG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_load,
  input  logic [ARG_W-1:0]  row_y,
  input  logic [ADDR_W-1:0] lin,
  input  logic [ADDR_W-1:0] ppr,
  input  logic              step,
  output logic [PTR_W-1:0]  ptr_q
);
  logic [PTR_W-1:0] prod;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    prod   = PTR_W'(ppr) * PTR_W'(row_y);
    ptr_en = row_load || step;
    if (row_load) ptr_d = PTR_W'(lin) + prod;
    else          ptr_d = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/dag_addr_calc.sv
module dag_addr_calc
  import dag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ARG_W  = 16,
  parameter int PTR_W  = ADDR_W + ARG_W,
  parameter int SUM_W  = PTR_W + 2,
  parameter logic [SUM_W-1:0] LIMIT_WORDS = '0
) (
  input  logic [1:0]        op,
  input  logic [ARG_W-1:0]  arg,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] wofs,
  input  logic [ADDR_W-1:0] dofs,
  input  logic [ADDR_W-1:0] lwofs,
  input  logic [ADDR_W-1:0] opix,
  input  logic [PTR_W-1:0]  ptr,
  output logic              in_range,
  output logic [ADDR_W-1:0] byte_addr
);
  logic [SUM_W-1:0] word;

  always_comb begin
    unique case (op)
      OP_WGT:  word = SUM_W'(wofs) + SUM_W'(lwofs) + SUM_W'(arg);
      OP_PIX:  word = SUM_W'(dofs) + SUM_W'(ptr);
      OP_OUT:  word = SUM_W'(dofs) + SUM_W'(opix) + SUM_W'(arg);
      default: word = '0;
    endcase
    in_range  = word < LIMIT_WORDS;
    byte_addr = base + ADDR_W'({word, 2'b00});
  end
endmodule

// File: rtl/dag_mem_port.sv
module dag_mem_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              reject,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic              issue_write,
  input  logic [DATA_W-1:0] issue_wdata,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              err
);
  logic valid_d;
  logic load_en;

  always_comb begin
    load_en = issue;
    if (issue)                      valid_d = 1'b1;
    else if (mem_valid && mem_ready) valid_d = 1'b0;
    else                            valid_d = mem_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      err       <= 1'b0;
    end else begin
      mem_valid <= valid_d;
      err       <= reject;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (load_en) begin
      mem_write <= issue_write;
      mem_addr  <= issue_addr;
      mem_wdata <= issue_wdata;
    end
  end
endmodule

// File: rtl/cnn_dram_addrgen.sv
module cnn_dram_addrgen
  import dag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ARG_W  = 16,
  parameter logic [ADDR_W-1:0] REGION_BASE  = 32'h3800_0000,
  parameter logic [ADDR_W-1:0] REGION_BYTES = 32'h0600_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  output logic              err
);
  localparam int PTR_W = ADDR_W + ARG_W;
  localparam int SUM_W = PTR_W + 2;
  localparam logic [SUM_W-1:0] LIMIT_WORDS = SUM_W'(REGION_BYTES >> 2);

  logic [ADDR_W-1:0] base_q, wofs_q, dofs_q, lwofs_q, lin_q, ppr_q, opix_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              in_range;
  logic [ADDR_W-1:0] calc_addr;
  logic              accept, is_mem, issue, reject, row_load, step;

  always_comb begin
    cmd_ready = !mem_valid;
    accept    = cmd_valid && cmd_ready;
    is_mem    = cmd_op != OP_ROW;
    issue     = accept && is_mem && in_range;
    reject    = accept && is_mem && !in_range;
    row_load  = accept && (cmd_op == OP_ROW);
    step      = issue && (cmd_op == OP_PIX);
  end

  dag_cfg_regs #(.ADDR_W(ADDR_W), .RESET_BASE(REGION_BASE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .base_q(base_q), .wofs_q(wofs_q), .dofs_q(dofs_q),
    .lwofs_q(lwofs_q), .lin_q(lin_q), .ppr_q(ppr_q), .opix_q(opix_q)
  );

  dag_pixel_ptr #(.ADDR_W(ADDR_W), .ARG_W(ARG_W), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .row_load(row_load), .row_y(cmd_arg),
    .lin(lin_q), .ppr(ppr_q), .step(step), .ptr_q(ptr_q)
  );

  dag_addr_calc #(
    .ADDR_W(ADDR_W), .ARG_W(ARG_W), .PTR_W(PTR_W), .SUM_W(SUM_W),
    .LIMIT_WORDS(LIMIT_WORDS)
  ) u_calc (
    .op(cmd_op), .arg(cmd_arg), .base(base_q), .wofs(wofs_q), .dofs(dofs_q),
    .lwofs(lwofs_q), .opix(opix_q), .ptr(ptr_q), .in_range(in_range),
    .byte_addr(calc_addr)
  );

  dag_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .issue(issue), .reject(reject),
    .issue_addr(calc_addr), .issue_write(cmd_op == OP_OUT),
    .issue_wdata(cmd_wdata), .mem_ready(mem_ready), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .err(err)
  );
endmodule

// File: rtl/dag_chk.sv
module dag_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              err
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)); // R7
  AST_REQ_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(cmd_valid && cmd_ready && cmd_op != 2'd3)); // R7
  AST_ROW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'd3 |=> !mem_valid && !err); // R3
  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mem_valid); // R6
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00); // R8
endmodule

bind cnn_dram_addrgen dag_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .err(err)
);

// File: tb/sim_cnn_dram_addrgen.sv
`timescale 1ns/1ps
module sim_cnn_dram_addrgen;
  localparam longint RW = 64'h0180_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [15:0] cmd_arg = '0;
  logic [31:0] cmd_wdata = '0;
  logic        cmd_ready, mem_valid, mem_write, err;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  longint base = 64'h3800_0000;

  always #10 clk = ~clk;

  cnn_dram_addrgen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(input [2:0] sel, input [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Issue one command; check request or error; stall once with a
  // command poked while busy (R7), then release the request.
  task automatic exec(input [1:0] op, input [15:0] arg, input [31:0] wd,
                      input bit ev, input bit ee, input longint ea,
                      input bit ew, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(mem_valid == ev, {tag, " valid"}, longint'(mem_valid), longint'(ev));
    chk(err == ee, {tag, " err"}, longint'(err), longint'(ee));
    if (ev && mem_valid) begin
      chk(mem_addr == 32'(ea), {tag, " addr"}, longint'(mem_addr), ea);
      chk(mem_write == ew, {tag, " write"}, longint'(mem_write), longint'(ew));
      if (ew) chk(mem_wdata == wd, {tag, " wdata"}, longint'(mem_wdata), longint'(wd));
      chk(!cmd_ready, "R7 busy ready", longint'(cmd_ready), 0);
      cmd_valid = 1'b1; cmd_op = 2'd1; cmd_arg = 16'h55;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(mem_valid && mem_addr == 32'(ea), "R7 held", longint'(mem_addr), ea);
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      chk(!mem_valid && cmd_ready, "R7 release", longint'(mem_valid), 0);
    end else if (ee) begin
      @(negedge clk);
      chk(!err, "R6 err one cycle", longint'(err), 0);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint wo, lwo, dof, lin, ppr, opx, p;
    repeat (3) @(negedge clk);
    chk(!mem_valid && cmd_ready && !err, "R1 reset outputs", longint'(mem_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset base 0x3800_0000, all offsets zero
    exec(2'd0, 16'd0, 0, 1, 0, base, 0, "R1 reset base");

    // R2/R9 weight sweep over two layer offsets
    wo = 64'd7; cfg(3'd1, 32'(wo));
    for (int l = 0; l < 2; l++) begin
      lwo = 64'd100 + l * 64'd300;
      cfg(3'd3, 32'(lwo));
      for (int i = 0; i < 24; i++)
        exec(2'd0, 16'(i * 5), 0, 1, 0, base + 4 * (wo + lwo + i * 5), 0, "R2 weight");
    end

    // R3/R4 rows of 12 words, streaming reads
    dof = 64'd5000; lin = 64'd40; ppr = 64'd12;
    cfg(3'd2, 32'(dof)); cfg(3'd4, 32'(lin)); cfg(3'd5, 32'(ppr));
    for (int y = 0; y < 4; y++) begin
      exec(2'd3, 16'(y), 0, 0, 0, 0, 0, "R3 row select");
      for (int k = 0; k < 12; k++)
        exec(2'd1, 0, 0, 1, 0, base + 4 * (dof + lin + ppr * y + k), 0, "R4 pixel");
    end
    // R3: reselect mid-row restarts pointer
    exec(2'd3, 16'd2, 0, 0, 0, 0, 0, "R3 reselect");
    exec(2'd1, 0, 0, 1, 0, base + 4 * (dof + lin + ppr * 2), 0, "R3 restart");
    exec(2'd1, 0, 0, 1, 0, base + 4 * (dof + lin + ppr * 2 + 1), 0, "R4 next");

    // R5 output writes over two pixel offsets
    for (int q = 0; q < 2; q++) begin
      opx = 64'd900 + q * 64'd64;
      cfg(3'd6, 32'(opx));
      for (int c = 0; c < 8; c++)
        exec(2'd2, 16'(c), 32'hA500_0000 + 32'(c * 17 + q), 1, 0,
             base + 4 * (dof + opx + c), 1, "R5 output");
    end

    // R9: base register rewrite
    base = 64'h1000_0000; cfg(3'd0, 32'(base));
    exec(2'd0, 16'd3, 0, 1, 0, base + 4 * (wo + lwo + 3), 0, "R9 base");
    base = 64'h3800_0000; cfg(3'd0, 32'(base));

    // R6 weight at the window edge
    wo = 0; cfg(3'd1, 0);
    lwo = RW - 50; cfg(3'd3, 32'(lwo));
    exec(2'd0, 16'd49, 0, 1, 0, base + 4 * (RW - 1), 0, "R6 weight last word");
    chk(32'(base + 4 * (RW - 1)) == 32'h3DFF_FFFC, "R6 edge const", base + 4 * (RW - 1), 64'h3DFF_FFFC);
    exec(2'd0, 16'd50, 0, 0, 1, 0, 0, "R6 weight past end");
    // R6 output past end
    cfg(3'd2, 32'(RW - 10)); cfg(3'd6, 0);
    exec(2'd2, 16'd10, 32'h1, 0, 1, 0, 0, "R6 output past end");

    // R6 pixel pointer held on rejected read
    dof = RW - 1 - 40 - 12; lin = 40; ppr = 12;
    cfg(3'd2, 32'(dof)); cfg(3'd4, 32'(lin)); cfg(3'd5, 32'(ppr));
    exec(2'd3, 16'd1, 0, 0, 0, 0, 0, "R3 row near end");
    p = lin + ppr;
    exec(2'd1, 0, 0, 1, 0, base + 4 * (dof + p), 0, "R6 pixel last word");
    exec(2'd1, 0, 0, 0, 1, 0, 0, "R6 pixel past end");
    dof = dof - 1; cfg(3'd2, 32'(dof));
    exec(2'd1, 0, 0, 1, 0, base + 4 * (dof + p + 1), 0, "R6 pointer unchanged");

    // R8 alignment spot check on last request
    chk(mem_addr[1:0] == 2'b00, "R8 aligned", longint'(mem_addr[1:0]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule